// File: doc/BRIEF.md
# Reset Sequencer with Vector Selection

This block controls reset for a microcontroller core. It gathers five internal reset requests and a bidirectional, active-low reset pin. Power-on, low-voltage, illegal-address, watchdog-timeout and clock-monitor requests arrive as synchronous one-bit inputs. Once a reset starts, the block holds the core in reset for a fixed sequence of 192 system-clock cycles. It pulls the pin low through an open-drain enable for the first 128 of those cycles and then lets it go. In the last cycle of the sequence it samples the pin. A pin that is still low shows that something outside the chip is holding reset. In that case the core stays in reset until the pin rises.

When the core reset ends, the block reports which reset vector the core should fetch, together with a one-cycle valid strobe. The pin level it sampled and two pending flags decide the vector. The flags record watchdog and clock-monitor requests. They are set when the request arrives and cleared when the sequence ends. A new internal request during a sequence starts the count again from cycle 0. The pin read-back is asynchronous, so it goes through a two-flop synchronizer before any logic uses it.

The synchronous active-high `rst` acts as a power-on event. While it is asserted, and on the cycle it is released, it restarts the sequence with no flag pending.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst` is high, `core_rst` and `pin_drive_low` are 1 and `vec_valid` is 0. The sequence then runs from cycle 0 as if from the last `rst` edge, and ends with vector code 00.
- R2: An internal request sampled on a clock edge makes `core_rst` 1 from that edge onwards for exactly 192 cycles, as long as the pin reads high at the end. `core_rst` then returns to 0 on a clock edge.
- R3: `pin_drive_low` is 1 for exactly the first 128 cycles of a sequence and 0 for its last 64 cycles.
- R4: If the synchronized pin reads low in the last cycle of the sequence, `core_rst` stays 1 until the pin rises. It falls on the third clock edge after the pin goes high.
- R5: A low pin while the block is idle starts a sequence on the third clock edge after the pin falls: two synchronizer edges and then the start edge.
- R6: If the pin was sampled low, the vector code is 00 (power-on/external), whatever flags are pending.
- R7: If the pin was sampled high and a clock-monitor request is pending, the vector code is 01, whatever the watchdog flag holds.
- R8: If the pin was sampled high and only a watchdog request is pending, the code is 10. With neither flag pending, the code is 00.
- R9: An internal request during a running sequence restarts it from cycle 0, so both the 192-cycle hold and the 128-cycle drive start again. The request's flag is kept.
- R10: Pending flags are cleared when a sequence ends. A later sequence with no watchdog or clock-monitor request reports code 00.
- R11: `vec_valid` is 1 for exactly one cycle: the first cycle in which `core_rst` is 0 after a sequence. `vec_sel` holds the selected code in that cycle. Code 11 is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, treated as a power-on event |
| por_req | input | 1 | Power-on reset request |
| lvr_req | input | 1 | Low-voltage reset request |
| ill_req | input | 1 | Illegal-address reset request |
| wdog_req | input | 1 | Watchdog timeout reset request |
| cmon_req | input | 1 | Clock-monitor failure reset request |
| pin_in | input | 1 | Asynchronous read-back of the reset pin, low = asserted |
| pin_drive_low | output | 1 | Open-drain enable that pulls the reset pin low |
| core_rst | output | 1 | Registered internal reset for the core |
| vec_sel | output | 2 | Vector code: 00 power-on/external, 01 clock monitor, 10 watchdog |
| vec_valid | output | 1 | One-cycle strobe marking `vec_sel` valid |

## Verification
The assertions take three things for granted about the inputs:
- The request inputs are synchronous to `clk`.
- The pin read-back is low whenever `pin_drive_low` is set, as a wired open-drain net would be.
- Outside forces pull the pin only low, never high.

The bench keeps to these assumptions. It models the pin as the inverted OR of the block's drive enable and its own external pull-down. It changes requests and the external pull only on falling clock edges, and it holds external pulls long enough to cross the synchronizer.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    VEC_PWR  = 2'b00,
    VEC_CMON = 2'b01,
    VEC_WDOG = 2'b10
  } vec_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_HOLD = 2'b10
  } st_e;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  // Chain resets to the released (high) pin level.
  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];

endmodule

// File: rtl/rsq_pend.sv
module rsq_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flg
);

  // One sticky flag per source; a set in the same cycle as clear wins.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flg[i] <= 1'b0;
      else if (set[i]) flg[i] <= 1'b1;
      else if (clr)    flg[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/rsq_vecpick.sv
module rsq_vecpick
  import rsq_pkg::*;
(
  input  logic pin_hi,
  input  logic cmon_f,
  input  logic wdog_f,
  output vec_e vec
);

  always_comb begin
    if (!pin_hi)     vec = VEC_PWR;   // external hold overrides flags
    else if (cmon_f) vec = VEC_CMON;
    else if (wdog_f) vec = VEC_WDOG;
    else             vec = VEC_PWR;
  end

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rsq_pkg::*;
#(
  parameter int DRV_LEN     = 128,
  parameter int SMP_DLY     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_req,
  input  logic       lvr_req,
  input  logic       ill_req,
  input  logic       wdog_req,
  input  logic       cmon_req,
  input  logic       pin_in,
  output logic       pin_drive_low,
  output logic       core_rst,
  output logic [1:0] vec_sel,
  output logic       vec_valid
);

  localparam int SEQ_LEN = DRV_LEN + SMP_DLY;
  localparam int CW      = $clog2(SEQ_LEN);

  logic          pin_s;
  logic          any_req;
  st_e           st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          fin;
  logic [1:0]    flg;
  vec_e          pick;
  vec_e          vec_q;
  logic          core_q, drv_q, vld_q;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  assign any_req = por_req | lvr_req | ill_req | wdog_req | cmon_req;

  // flg[1] = clock monitor, flg[0] = watchdog
  rsq_pend #(.N(2)) u_pend (
    .clk (clk),
    .rst (rst),
    .set ({cmon_req, wdog_req}),
    .clr (fin),
    .flg (flg)
  );

  // An end from RUN means the pin read high; an end from HOLD means it read low.
  rsq_vecpick u_pick (
    .pin_hi (st_q == ST_RUN),
    .cmon_f (flg[1]),
    .wdog_f (flg[0]),
    .vec    (pick)
  );

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    fin   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (any_req || !pin_s) begin
          st_n  = ST_RUN;
          cnt_n = '0;
        end
      end
      ST_RUN: begin
        if (any_req) begin
          cnt_n = '0;
        end else if (cnt_q == CW'(SEQ_LEN - 1)) begin
          if (pin_s) begin
            st_n = ST_IDLE;
            fin  = 1'b1;
          end else begin
            st_n = ST_HOLD;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (any_req) begin
          st_n  = ST_RUN;
          cnt_n = '0;
        end else if (pin_s) begin
          st_n = ST_IDLE;
          fin  = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      core_q <= 1'b1;
      drv_q  <= 1'b1;
      vld_q  <= 1'b0;
      vec_q  <= VEC_PWR;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      core_q <= (st_n != ST_IDLE);
      drv_q  <= (st_n == ST_RUN) && (cnt_n < CW'(DRV_LEN));
      vld_q  <= fin;
      if (fin) vec_q <= pick;
    end
  end

  assign pin_drive_low = drv_q;
  assign core_rst      = core_q;
  assign vec_sel       = vec_q;
  assign vec_valid     = vld_q;

endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
  parameter int DRV_LEN = 128,
  parameter int SMP_DLY = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       por_req,
  input logic       lvr_req,
  input logic       ill_req,
  input logic       wdog_req,
  input logic       cmon_req,
  input logic       pin_drive_low,
  input logic       core_rst,
  input logic [1:0] vec_sel,
  input logic       vec_valid
);

  localparam int SEQ_LEN = DRV_LEN + SMP_DLY;

  logic        any_req;
  logic [15:0] run_len;

  assign any_req = por_req | lvr_req | ill_req | wdog_req | cmon_req;

  // Counts consecutive cycles with core reset asserted.
  always_ff @(posedge clk) begin
    if (rst)           run_len <= '0;
    else if (core_rst) run_len <= (run_len == 16'hFFFF) ? run_len : run_len + 16'd1;
    else               run_len <= '0;
  end

  a_r2_min_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (run_len >= 16'(SEQ_LEN)));

  a_r3_drive_inside_reset: assert property (@(posedge clk) disable iff (rst)
    pin_drive_low |-> core_rst);

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    any_req |=> (core_rst && pin_drive_low));

  a_r11_strobe_single: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  a_r11_strobe_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> vec_valid);

  a_r11_strobe_out_of_reset: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> !core_rst);

  a_r11_legal_code: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_sel != 2'b11));

endmodule

bind reset_sequencer rsq_chk #(.DRV_LEN(DRV_LEN), .SMP_DLY(SMP_DLY)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .por_req       (por_req),
  .lvr_req       (lvr_req),
  .ill_req       (ill_req),
  .wdog_req      (wdog_req),
  .cmon_req      (cmon_req),
  .pin_drive_low (pin_drive_low),
  .core_rst      (core_rst),
  .vec_sel       (vec_sel),
  .vec_valid     (vec_valid)
);

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;

  localparam int DRV = 128;
  localparam int SMP = 64;
  localparam int SEQ = DRV + SMP;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_req = 1'b0, lvr_req = 1'b0, ill_req = 1'b0;
  logic       wdog_req = 1'b0, cmon_req = 1'b0;
  logic       ext_low = 1'b0;
  logic       pin_in;
  logic       pin_drive_low, core_rst, vec_valid;
  logic [1:0] vec_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // Open-drain wired pin: low if the block or the outside world pulls it.
  assign pin_in = ~(pin_drive_low | ext_low);

  reset_sequencer #(.DRV_LEN(DRV), .SMP_DLY(SMP), .SYNC_STAGES(2)) dut (
    .clk           (clk),
    .rst           (rst),
    .por_req       (por_req),
    .lvr_req       (lvr_req),
    .ill_req       (ill_req),
    .wdog_req      (wdog_req),
    .cmon_req      (cmon_req),
    .pin_in        (pin_in),
    .pin_drive_low (pin_drive_low),
    .core_rst      (core_rst),
    .vec_sel       (vec_sel),
    .vec_valid     (vec_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mask bits: {por, lvr, ill, wdog, cmon}
  task automatic fire(input logic [4:0] m);
    @(negedge clk);
    {por_req, lvr_req, ill_req, wdog_req, cmon_req} = m;
    @(negedge clk);
    {por_req, lvr_req, ill_req, wdog_req, cmon_req} = 5'b0;
  endtask

  // Counts samples with core reset high from the current negedge on.
  task automatic measure(input int exp_cr, input int exp_dv, input int exp_vec, input string tag);
    int cr = 0;
    int dv = 0;
    int guard = 0;
    while (core_rst === 1'b1 && guard < 20000) begin
      cr++;
      if (pin_drive_low === 1'b1) dv++;
      @(negedge clk);
      guard++;
    end
    chk(cr == exp_cr, {tag, " R2 hold length"}, cr, exp_cr);
    chk(dv == exp_dv, {tag, " R3 drive length"}, dv, exp_dv);
    chk(vec_valid === 1'b1, {tag, " R11 strobe at release"}, int'(vec_valid), 1);
    chk(int'(vec_sel) == exp_vec, {tag, " vector code"}, int'(vec_sel), exp_vec);
    @(negedge clk);
    chk(vec_valid === 1'b0, {tag, " R11 strobe one cycle"}, int'(vec_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(core_rst === 1'b1, "R1 core reset during rst", int'(core_rst), 1);
    chk(pin_drive_low === 1'b1, "R1 drive during rst", int'(pin_drive_low), 1);
    chk(vec_valid === 1'b0, "R1 no strobe during rst", int'(vec_valid), 0);
    rst = 1'b0;
    measure(SEQ, DRV, 0, "R1 after rst");

    repeat (5) @(negedge clk);
    chk(core_rst === 1'b0, "R2 idle core reset low", int'(core_rst), 0);
    chk(pin_drive_low === 1'b0, "R3 idle no drive", int'(pin_drive_low), 0);

    fire(5'b01000); measure(SEQ, DRV, 0, "R8 low-voltage none pending");
    fire(5'b00010); measure(SEQ, DRV, 2, "R8 watchdog");
    fire(5'b00001); measure(SEQ, DRV, 1, "R7 clock monitor");
    fire(5'b00011); measure(SEQ, DRV, 1, "R7 clock monitor over watchdog");
    fire(5'b10000); measure(SEQ, DRV, 0, "R10 power-on after flags");
    fire(5'b00100); measure(SEQ, DRV, 0, "R10 illegal address");

    // R9: restart at cycle 100 with a watchdog request
    begin
      int hi = 0;
      fire(5'b01000);
      for (int i = 0; i < 98; i++) begin
        @(negedge clk);
        if (core_rst === 1'b1) hi++;
      end
      chk(hi == 98, "R9 reset held before restart", hi, 98);
      fire(5'b00010);
      measure(SEQ, DRV, 2, "R9 restart");
    end

    // R5: short external pull starts a sequence on the third edge
    @(negedge clk); ext_low = 1'b1;
    repeat (2) @(negedge clk);
    chk(core_rst === 1'b0, "R5 not started after two edges", int'(core_rst), 0);
    @(negedge clk);
    chk(core_rst === 1'b1, "R5 started on third edge", int'(core_rst), 1);
    ext_low = 1'b0;
    measure(SEQ, DRV, 0, "R5 external short");

    // R4: long external hold
    @(negedge clk); ext_low = 1'b1;
    repeat (300) @(negedge clk);
    chk(core_rst === 1'b1, "R4 held past sequence", int'(core_rst), 1);
    chk(vec_valid === 1'b0, "R4 no strobe while held", int'(vec_valid), 0);
    ext_low = 1'b0;
    measure(3, 0, 0, "R4 release after pin rise");

    // R6: clock monitor pending but pin held low at the sample
    @(negedge clk); ext_low = 1'b1; cmon_req = 1'b1;
    @(negedge clk); cmon_req = 1'b0;
    repeat (250) @(negedge clk);
    ext_low = 1'b0;
    measure(3, 0, 0, "R6 pin low overrides flag");
    fire(5'b01000); measure(SEQ, DRV, 0, "R10 clock flag cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule